// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline Core

This block is a small in-order processor pipeline with five stages: fetch, operand read, execute/branch, memory access and write-back. Each stage is separated from the next by clocked staging registers. Instruction and data memories are external and both have a fixed one-cycle read latency. The core issues one fetch address per cycle and one data access per cycle. Neither memory port has a valid/ready handshake or back-pressure, so each memory must return read data on the cycle after it is addressed, every time.

The instruction set has five operations: register add, add-immediate, load, store, and a branch taken when a register equals zero. Every instruction carries its own fetch address down the pipe. The branch target is formed in the execute stage from that address, not from the fetch counter, which has already moved on by then. There is no forwarding and no interlock. Software must space dependent instructions with no-ops. A taken branch cancels the two younger instructions behind it.

Instruction word layout:
- bits 31:26 hold the opcode.
- bits 25:21 hold the destination register. For a store, this field holds the data register.
- bits 20:16 hold the first source register, which is the base register for loads and stores.
- bits 15:11 hold the second source register for a register add.
- bits 15:0 hold a signed 16-bit immediate, displacement or byte offset.

Opcodes:

| Opcode | Operation |
|---|---|
| 0 | no-op |
| 1 | add |
| 2 | add-immediate |
| 3 | load |
| 4 | store |
| 5 | branch-if-zero |

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted, `imem_addr` is 0 and `dmem_we` is 0. All registers read as zero after reset. The first fetch after reset is from address 0.
- R2: When no branch is taken, `imem_addr` increases by 4 on every clock.
- R3: Add (opcode 1) writes rs1 + rs2 into rd. The fields are rd[25:21], rs1[20:16] and rs2[15:11].
- R4: Add-immediate (opcode 2) writes rs1 plus the sign-extended imm[15:0] into rd.
- R5: Load (opcode 3) reads data memory at rs1 + sext(imm) and writes the word it returns into rd.
- R6: Store (opcode 4) writes the register named in bits 25:21 to data memory at rs1 + sext(imm). No register changes.
- R7: Branch-if-zero (opcode 5) with rs1 == 0 makes the next fetch address the branch's own fetch address plus sext(imm). The offset is in bytes and may be negative or zero.
- R8: A taken branch cancels the two instructions fetched after it. They change neither registers nor memory.
- R9: Branch-if-zero with rs1 != 0 changes nothing, and fetch continues sequentially.
- R10: Register 0 always reads 0. Writes to it are discarded.
- R11: A result is readable by the third instruction after its producer. The first and second instructions after the producer still read the old value.
- R12: Opcodes 6 to 63 behave as no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | XLEN | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word for the address presented one cycle earlier |
| dmem_addr | output | XLEN | Data memory byte address |
| dmem_wdata | output | XLEN | Store data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_re | output | 1 | Data memory read strobe |
| dmem_rdata | input | XLEN | Load data for the address presented one cycle earlier |

## Verification
The hardest case to reach from the ports is the exact hazard window. The bench must show that the first and second consumers after a producer read the stale register value and only the third reads the new one. It must also show that both instructions behind a taken branch vanish without a trace.

Hand-built programs place a producer followed by three stores at distances one, two and three. Stores sit directly behind each taken branch. Data memory is pre-filled with a marker pattern, so a stale value, a wrongly surviving store and a correct write are all distinguishable. A further program sweeps the immediate field across many signed values.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int INSN_W  = 32;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int OPC_LSB = 26;
  localparam int RD_LSB  = 21;
  localparam int RS1_LSB = 16;
  localparam int RS2_LSB = 11;

  typedef enum logic [5:0] {
    OP_NOP   = 6'd0,
    OP_ADD   = 6'd1,
    OP_ADDI  = 6'd2,
    OP_LOAD  = 6'd3,
    OP_STORE = 6'd4,
    OP_BRZ   = 6'd5
  } op_e;

  function automatic logic op_writes_reg(op_e op);
    return (op == OP_ADD) || (op == OP_ADDI) || (op == OP_LOAD);
  endfunction
endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][AW-1:0]    rd_idx,
  output logic [NRD-1:0][XLEN-1:0]  rd_val,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_idx,
  input  logic [XLEN-1:0]           wr_val
);
  logic [NREG-1:0][XLEN-1:0] regs;

  // Entry 0 is never written, so it stays at its reset value of zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs <= '0;
    else if (wr_en && (wr_idx != '0)) regs[wr_idx] <= wr_val;
  end

  // Write-before-read: a write in this cycle is visible to a read in the same cycle.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_idx[p] == '0)                      rd_val[p] = '0;
      else if (wr_en && (wr_idx == rd_idx[p]))  rd_val[p] = wr_val;
      else                                      rd_val[p] = regs[rd_idx[p]];
    end
  end

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx != '0)) |=> (regs[$past(wr_idx)] == $past(wr_val)));
endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode import pipe5_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [INSN_W-1:0] insn,
  output op_e               op,
  output logic [RIDX_W-1:0] rd,
  output logic [RIDX_W-1:0] rs1,
  output logic [RIDX_W-1:0] rs2,
  output logic [XLEN-1:0]   imm
);
  logic [5:0] opc;
  assign opc = insn[OPC_LSB +: 6];
  assign rd  = insn[RD_LSB  +: RIDX_W];
  assign rs1 = insn[RS1_LSB +: RIDX_W];
  assign rs2 = insn[RS2_LSB +: RIDX_W];
  assign imm = {{(XLEN-IMM_W){insn[IMM_W-1]}}, insn[IMM_W-1:0]};

  // Undefined opcodes fall back to a no-op.
  always_comb begin
    if (opc <= 6'd5) op = op_e'(opc);
    else             op = OP_NOP;
  end
endmodule

// File: rtl/pipe5_exec.sv
module pipe5_exec import pipe5_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic            valid,
  input  op_e             op,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] sum,
  output logic            taken,
  output logic [XLEN-1:0] target
);
  // Add, add-immediate and address generation all share one adder.
  assign sum    = opa + opb;
  assign target = pc + opb;
  assign taken  = valid && (op == OP_BRZ) && (opa == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core import pipe5_pkg::*; #(
  parameter int              XLEN   = 32,
  parameter int              NREG   = 32,
  parameter logic [XLEN-1:0] RST_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic [XLEN-1:0]   dmem_addr,
  output logic [XLEN-1:0]   dmem_wdata,
  output logic              dmem_we,
  output logic              dmem_re,
  input  logic [XLEN-1:0]   dmem_rdata
);
  localparam int AW = $clog2(NREG);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // fetch stage
  logic [XLEN-1:0] pc_q;
  // operand stage (the instruction word arrives from memory on imem_rdata)
  logic            of_valid_q;
  logic [XLEN-1:0] of_pc_q;
  // execute stage
  logic            ex_valid_q;
  op_e             ex_op_q;
  logic [AW-1:0]   ex_rd_q;
  logic [XLEN-1:0] ex_pc_q, ex_a_q, ex_b_q, ex_sd_q;
  // memory stage
  logic            mem_valid_q;
  op_e             mem_op_q;
  logic [AW-1:0]   mem_rd_q;
  logic [XLEN-1:0] mem_res_q, mem_sd_q;
  // write-back stage
  logic            wb_valid_q;
  op_e             wb_op_q;
  logic [AW-1:0]   wb_rd_q;
  logic [XLEN-1:0] wb_res_q;

  op_e             dec_op;
  logic [RIDX_W-1:0] dec_rd, dec_rs1, dec_rs2;
  logic [XLEN-1:0] dec_imm;
  logic [1:0][AW-1:0]   rf_idx;
  logic [1:0][XLEN-1:0] rf_val;
  logic            wb_en;
  logic [XLEN-1:0] wb_val;
  logic [XLEN-1:0] ex_sum, br_target;
  logic            br_taken;

  // ---------------- fetch ----------------
  assign imem_addr = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= RST_PC;
      of_valid_q <= 1'b0;
      of_pc_q    <= '0;
    end else begin
      pc_q       <= br_taken ? br_target : pc_q + STEP;
      of_valid_q <= !br_taken;
      of_pc_q    <= pc_q;
    end
  end

  // ---------------- operand read ----------------
  pipe5_decode #(.XLEN(XLEN)) u_dec (
    .insn(imem_rdata), .op(dec_op), .rd(dec_rd), .rs1(dec_rs1),
    .rs2(dec_rs2), .imm(dec_imm)
  );

  // Port 0 reads the base / first source; port 1 reads either the second source or the store data.
  assign rf_idx[0] = AW'(dec_rs1);
  assign rf_idx[1] = (dec_op == OP_STORE) ? AW'(dec_rd) : AW'(dec_rs2);

  pipe5_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(2)) u_rf (
    .clk(clk), .rst_n(rst_n), .rd_idx(rf_idx), .rd_val(rf_val),
    .wr_en(wb_en), .wr_idx(wb_rd_q), .wr_val(wb_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid_q <= 1'b0;
      ex_op_q    <= OP_NOP;
      ex_rd_q    <= '0;
      ex_pc_q    <= '0;
      ex_a_q     <= '0;
      ex_b_q     <= '0;
      ex_sd_q    <= '0;
    end else begin
      ex_valid_q <= of_valid_q && !br_taken;
      ex_op_q    <= dec_op;
      ex_rd_q    <= AW'(dec_rd);
      ex_pc_q    <= of_pc_q;
      ex_a_q     <= rf_val[0];
      ex_b_q     <= (dec_op == OP_ADD) ? rf_val[1] : dec_imm;
      ex_sd_q    <= rf_val[1];
    end
  end

  // ---------------- execute / branch ----------------
  pipe5_exec #(.XLEN(XLEN)) u_ex (
    .valid(ex_valid_q), .op(ex_op_q), .pc(ex_pc_q), .opa(ex_a_q), .opb(ex_b_q),
    .sum(ex_sum), .taken(br_taken), .target(br_target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid_q <= 1'b0;
      mem_op_q    <= OP_NOP;
      mem_rd_q    <= '0;
      mem_res_q   <= '0;
      mem_sd_q    <= '0;
    end else begin
      mem_valid_q <= ex_valid_q;
      mem_op_q    <= ex_op_q;
      mem_rd_q    <= ex_rd_q;
      mem_res_q   <= ex_sum;
      mem_sd_q    <= ex_sd_q;
    end
  end

  // ---------------- memory access ----------------
  assign dmem_addr  = mem_res_q;
  assign dmem_wdata = mem_sd_q;
  assign dmem_we    = mem_valid_q && (mem_op_q == OP_STORE);
  assign dmem_re    = mem_valid_q && (mem_op_q == OP_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_q <= 1'b0;
      wb_op_q    <= OP_NOP;
      wb_rd_q    <= '0;
      wb_res_q   <= '0;
    end else begin
      wb_valid_q <= mem_valid_q;
      wb_op_q    <= mem_op_q;
      wb_rd_q    <= mem_rd_q;
      wb_res_q   <= mem_res_q;
    end
  end

  // ---------------- write-back ----------------
  assign wb_en  = wb_valid_q && op_writes_reg(wb_op_q);
  assign wb_val = (wb_op_q == OP_LOAD) ? dmem_rdata : wb_res_q;

  // ---------------- assertions ----------------
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> (pc_q == $past(pc_q) + STEP));

  p_branch_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (pc_q == $past(br_target)));

  p_squash_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (!of_valid_q && !ex_valid_q));

  p_store_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> $past(ex_valid_q && (ex_op_q == OP_STORE)));
endmodule

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  localparam logic [5:0] C_NOP = 6'd0, C_ADD = 6'd1, C_ADDI = 6'd2,
                         C_LD = 6'd3, C_ST = 6'd4, C_BRZ = 6'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] trace [40];
  int n_chk = 0, n_bad = 0, wp = 0;

  always #5 clk = ~clk;

  pipe5_core dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  // One-cycle synchronous memories.
  always @(posedge clk) begin
    imem_rdata <= imem[imem_addr[7:2]];
    dmem_rdata <= dmem[dmem_addr[7:2]];
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] enc_i(logic [5:0] op, int rd, int rs1, logic [15:0] imm);
    return {op, 5'(rd), 5'(rs1), imm};
  endfunction
  function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int rs1, int rs2);
    return {op, 5'(rd), 5'(rs1), 5'(rs2), 11'd0};
  endfunction
  function automatic logic [31:0] fill(int i);
    return 32'hA5A5_0000 | 32'(i);
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[wp] = w;
    wp++;
  endtask

  task automatic clear_mems();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] = fill(i);
    end
    wp = 0;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_prog(input int cycles);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(imem_addr, 32'd0, "R1 fetch address in reset");
    check(32'(dmem_we), 32'd0, "R1 no store in reset");
    rst_n = 1'b1;
    trace[0] = imem_addr;
    for (int c = 1; c < cycles; c++) begin
      @(negedge clk);
      if (c < 40) trace[c] = imem_addr;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    // ---------- program A: arithmetic, memory, r0, hazards, bad opcode ----------
    clear_mems();
    emit(enc_i(C_ADDI, 1, 0, 16'd5));
    emit(enc_i(C_ADDI, 2, 0, 16'hFFFD));
    emit(0); emit(0);
    emit(enc_r(C_ADD, 3, 1, 2));
    emit(enc_i(C_ADDI, 0, 1, 16'd7));
    emit(0); emit(0);
    emit(enc_i(C_ADDI, 4, 0, 16'h0040));
    emit(0); emit(0);
    emit(enc_i(C_ST, 3, 4, 16'd0));
    emit(enc_i(C_ST, 1, 4, 16'd4));
    emit(enc_i(C_ST, 2, 4, 16'hFFFC));
    emit(enc_i(C_LD, 5, 4, 16'd4));
    emit(0); emit(0);
    emit(enc_i(C_ST, 5, 4, 16'd8));
    emit(enc_i(C_ADDI, 6, 0, 16'd9));
    emit(enc_i(C_ST, 6, 4, 16'd12));
    emit(enc_i(C_ST, 6, 4, 16'd16));
    emit(enc_i(C_ST, 6, 4, 16'd20));
    emit(enc_i(C_ADDI, 7, 0, 16'h7FFF));
    emit(0); emit(0);
    emit(enc_i(C_ST, 7, 4, 16'd24));
    emit(enc_i(C_ADDI, 8, 0, 16'h8000));
    emit(0); emit(0);
    emit(enc_i(C_ST, 8, 4, 16'd28));
    emit(enc_i(6'h3F, 1, 0, 16'd1));
    emit(0); emit(0);
    emit(enc_i(C_ST, 1, 4, 16'd32));
    emit(enc_i(C_ST, 0, 4, 16'd36));
    emit(enc_i(C_BRZ, 0, 0, 16'd0));
    run_prog(120);
    for (int c = 0; c < 11; c++) check(trace[c], 32'(4 * c), "R2 sequential fetch");
    check(dmem[16], 32'd2,          "R3 add 5 + -3");
    check(dmem[17], 32'd5,          "R6 store word");
    check(dmem[15], 32'hFFFF_FFFD,  "R4 negative immediate / negative displacement");
    check(dmem[18], 32'd5,          "R5 load then store");
    check(dmem[19], 32'd0,          "R11 first consumer sees old value");
    check(dmem[20], 32'd0,          "R11 second consumer sees old value");
    check(dmem[21], 32'd9,          "R11 third consumer sees new value");
    check(dmem[22], 32'h0000_7FFF,  "R4 largest positive immediate");
    check(dmem[23], 32'hFFFF_8000,  "R4 most negative immediate");
    check(dmem[24], 32'd5,          "R12 undefined opcode leaves r1");
    check(dmem[25], 32'd0,          "R10 r0 reads zero after write attempt");

    // ---------- program B: branches and squash ----------
    clear_mems();
    emit(enc_i(C_ADDI, 1, 0, 16'd1));
    emit(enc_i(C_ADDI, 9, 0, 16'h0080));
    emit(0); emit(0);
    emit(enc_i(C_BRZ, 0, 1, 16'd100));
    emit(enc_i(C_ST, 1, 9, 16'd0));
    emit(enc_i(C_BRZ, 0, 0, 16'd20));
    emit(enc_i(C_ST, 1, 9, 16'd4));
    emit(enc_i(C_ST, 1, 9, 16'd8));
    emit(enc_i(C_ST, 1, 9, 16'd12));
    emit(0);
    emit(enc_i(C_ST, 1, 9, 16'd16));
    emit(enc_i(C_BRZ, 0, 0, 16'd12));
    emit(enc_i(C_ST, 1, 9, 16'd20));
    emit(enc_i(C_ST, 1, 9, 16'd24));
    emit(enc_i(C_BRZ, 0, 0, 16'd12));
    emit(enc_i(C_ST, 1, 9, 16'd28));
    emit(enc_i(C_ST, 1, 9, 16'd32));
    emit(enc_i(C_ST, 1, 9, 16'd36));
    emit(enc_i(C_BRZ, 0, 0, 16'd0));
    run_prog(120);
    check(trace[7], 32'd28, "R9 not-taken branch keeps sequential fetch");
    check(trace[8], 32'd32, "R2 fetch before branch resolves");
    check(trace[9], 32'd44, "R7 target = own pc 24 + 20");
    check(dmem[32], 32'd1,       "R9 instruction after not-taken branch runs");
    check(dmem[33], fill(33),    "R8 first squashed store");
    check(dmem[34], fill(34),    "R8 second squashed store");
    check(dmem[35], fill(35),    "R7 skipped instruction");
    check(dmem[36], 32'd1,       "R7 instruction at target runs");
    check(dmem[37], fill(37),    "R8 squash after second branch");
    check(dmem[38], fill(38),    "R8 squash after second branch");
    check(dmem[39], fill(39),    "R8 squash after third branch");
    check(dmem[40], fill(40),    "R8 squash after third branch");
    check(dmem[41], 32'd1,       "R7 third branch target");

    // ---------- program C: immediate sweep ----------
    clear_mems();
    for (int k = 0; k < 14; k++) begin
      logic [15:0] v;
      v = 16'(k * 16'h2493) ^ 16'(k << 12);
      emit(enc_i(C_ADDI, 1, 0, v));
      emit(0); emit(0);
      emit(enc_i(C_ST, 1, 0, 16'(4 * k)));
    end
    emit(enc_i(C_BRZ, 0, 0, 16'd0));
    run_prog(120);
    for (int k = 0; k < 14; k++) begin
      logic [15:0] v;
      v = 16'(k * 16'h2493) ^ 16'(k << 12);
      check(dmem[k], {{16{v[15]}}, v}, "R4 immediate sweep");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule